// File: doc/BRIEF.md
# Indirect Memory Window over a Byte-Serial Register Port

This block gives an external controller on a two-wire serial register port a way into a 16-bit address space that the port cannot reach directly. The serial slave in front of it decodes the transaction and hands over a stream of byte events: a new subaddress, a byte written by the controller, or a byte the controller is about to read. Three subaddresses are reserved for the window. One loads a write pointer. One loads a read address and starts a fetch. The third carries 16-bit data in both directions.

A write is made in two steps. The controller first sends the 16-bit target to the write-pointer subaddress. It then sends two data bytes to the data subaddress, and the internal write is issued once the second byte is in. A read is also split in two. The controller first writes the 16-bit source address to the read-address subaddress, and the low byte of that address starts the internal fetch. In a later transaction the controller selects the data subaddress and reads back the captured word, high byte first.

On the internal side there is a single request/acknowledge handshake. The request stays asserted until it is acknowledged. During that time `busy` tells the serial slave to hold the clock low, so that no further byte arrives before the access has finished.

Top module: `ixwin_bridge`

## Requirements
- R1: After reset `mem_req` and `busy` are low, and the read buffer holds 0x0000. Reading the data subaddress before any fetch has completed therefore returns 0x00 and then 0x00.
- R2: Two bytes written to the write-pointer subaddress (default code 0x36) set the write target to {first byte, second byte}.
- R3: On the data subaddress (default code 0x37), a first written byte alone starts no access. The second written byte starts one internal write with `mem_we`=1, `mem_wdata`={first, second} and `mem_addr` equal to the write target. `mem_req` is high in the cycle after the strobe of the second byte.
- R4: Two bytes written to the read-address subaddress (default code 0x35) start one internal read at {first, second}, with `mem_we`=0 and `mem_req` high in the cycle after the second strobe. The acknowledged `mem_rdata` is captured into the read buffer.
- R5: While the data subaddress is read, `rd_byte` shows the buffer's bits 15:8 and then, after one `rd_stb`, bits 7:0. Each new subaddress points the read side back at bits 15:8.
- R6: `busy` is high from the cycle after the launch until the cycle after `mem_ack`. Throughout the wait `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R7: A new subaddress restarts the byte pairing. A single byte left before it starts no access, and the next byte written counts as a first byte.
- R8: Bytes written under any other subaddress start no access and leave the write target unchanged.
- R9: Further byte pairs under the same subaddress repeat the action. A third and fourth data byte issue a second write to the same target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_stb | input | 1 | A new subaddress has been received |
| sub_code | input | 8 | Subaddress value, valid with `sub_stb` |
| wr_stb | input | 1 | A byte written by the controller is valid |
| wr_byte | input | 8 | Written byte, valid with `wr_stb` |
| rd_stb | input | 1 | The current `rd_byte` has been sent; step to the next |
| rd_byte | output | 8 | Byte offered to the controller on a read |
| busy | output | 1 | Internal access pending; hold the serial clock low |
| mem_req | output | 1 | Internal access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Internal address |
| mem_wdata | output | 16 | Internal write data |
| mem_rdata | input | 16 | Internal read data, valid with `mem_ack` |
| mem_ack | input | 1 | Internal access complete |

## Verification
The hardest case to produce is an abandoned pair: one byte is left under a subaddress, and then the selection changes before its partner arrives. Unless the next byte is checked for being treated as a first byte, the case goes unseen. The directed part of the stimulus sets this up for the data subaddress and for the read-address subaddress. It confirms through the access counters of the memory model that nothing was issued. A later completed pair must then show the fresh byte in the high half. The random part varies the acknowledge latency from zero to three cycles and mixes reads and writes. This covers the stretch window at every length.

// File: rtl/ixwin_pkg.sv
package ixwin_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    WIN_OTHER = 2'd0,
    WIN_RADDR = 2'd1,
    WIN_WADDR = 2'd2,
    WIN_DATA  = 2'd3
  } win_sel_e;

  // Pair two serial bytes into one internal word, high byte first.
  function automatic logic [WORD_W-1:0] pair_bytes(input logic [BYTE_W-1:0] hi,
                                                    input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  // Byte returned to the controller: half 0 is bits 15:8, half 1 is bits 7:0.
  function automatic logic [BYTE_W-1:0] word_half(input logic [WORD_W-1:0] w,
                                                   input logic            second);
    return second ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction

endpackage

// File: rtl/ixwin_pairer.sv
module ixwin_pairer
  import ixwin_pkg::*;
#(
  parameter logic [7:0] CODE_RADDR = 8'h35,
  parameter logic [7:0] CODE_WADDR = 8'h36,
  parameter logic [7:0] CODE_DATA  = 8'h37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_stb,
  input  logic [7:0]        sub_code,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              busy,
  output logic              go_write,
  output logic              go_read,
  output logic [WORD_W-1:0] go_addr,
  output logic [WORD_W-1:0] go_wdata,
  output logic              second_byte
);

  function automatic win_sel_e classify(input logic [7:0] code);
    if (code == CODE_RADDR)      return WIN_RADDR;
    else if (code == CODE_WADDR) return WIN_WADDR;
    else if (code == CODE_DATA)  return WIN_DATA;
    else                         return WIN_OTHER;
  endfunction

  win_sel_e          sel_q;
  logic              idx_q;
  logic [BYTE_W-1:0] first_q;
  logic [WORD_W-1:0] wtarget_q;
  logic              take;
  logic [WORD_W-1:0] joined;

  always_comb begin
    take     = wr_stb && !busy;
    joined   = pair_bytes(first_q, wr_byte);
    go_write = take && idx_q && (sel_q == WIN_DATA);
    go_read  = take && idx_q && (sel_q == WIN_RADDR);
    go_addr  = go_read ? joined : wtarget_q;
    go_wdata = joined;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= WIN_OTHER;
      idx_q     <= 1'b0;
      first_q   <= '0;
      wtarget_q <= '0;
    end else if (sub_stb) begin
      sel_q <= classify(sub_code);
      idx_q <= 1'b0;
    end else if (take) begin
      idx_q <= ~idx_q;
      if (!idx_q) first_q <= wr_byte;
      if (idx_q && (sel_q == WIN_WADDR)) wtarget_q <= joined;
    end
  end

  assign second_byte = idx_q;

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stb |=> !second_byte);

  assert_pair_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx_q && sel_q == WIN_WADDR) |=> wtarget_q[7:0] == $past(wr_byte));

endmodule

// File: rtl/ixwin_access.sv
module ixwin_access
  import ixwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_write,
  input  logic              go_read,
  input  logic [WORD_W-1:0] go_addr,
  input  logic [WORD_W-1:0] go_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] rd_buf
);

  logic launch;
  logic finish;

  always_comb begin
    launch = !mem_req && (go_write || go_read);
    finish = mem_req && mem_ack;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_buf    <= '0;
    end else if (launch) begin
      mem_req  <= 1'b1;
      mem_we   <= go_write;
      mem_addr <= go_addr;
      if (go_write) mem_wdata <= go_wdata;
    end else if (finish) begin
      mem_req <= 1'b0;
      if (!mem_we) rd_buf <= mem_rdata;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> rd_buf == $past(mem_rdata));

  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(go_write || go_read));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

endmodule

// File: rtl/ixwin_readout.sv
module ixwin_readout
  import ixwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_stb,
  input  logic              rd_stb,
  input  logic [WORD_W-1:0] rd_buf,
  output logic [BYTE_W-1:0] rd_byte
);

  logic half_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (sub_stb) half_q <= 1'b0;
    else if (rd_stb)  half_q <= ~half_q;
  end

  assign rd_byte = word_half(rd_buf, half_q);

  assert_ptr_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stb |=> (rd_byte == rd_buf[WORD_W-1:BYTE_W]) || $changed(rd_buf));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !sub_stb) |=> half_q != $past(half_q));

endmodule

// File: rtl/ixwin_bridge.sv
module ixwin_bridge
  import ixwin_pkg::*;
#(
  parameter logic [7:0] CODE_RADDR = 8'h35,
  parameter logic [7:0] CODE_WADDR = 8'h36,
  parameter logic [7:0] CODE_DATA  = 8'h37
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sub_stb,
  input  logic [7:0]  sub_code,
  input  logic        wr_stb,
  input  logic [7:0]  wr_byte,
  input  logic        rd_stb,
  output logic [7:0]  rd_byte,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ack
);

  logic              go_write;
  logic              go_read;
  logic [WORD_W-1:0] go_addr;
  logic [WORD_W-1:0] go_wdata;
  logic              second_byte;
  logic [WORD_W-1:0] rd_buf;

  ixwin_pairer #(
    .CODE_RADDR(CODE_RADDR),
    .CODE_WADDR(CODE_WADDR),
    .CODE_DATA (CODE_DATA)
  ) u_pairer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sub_stb    (sub_stb),
    .sub_code   (sub_code),
    .wr_stb     (wr_stb),
    .wr_byte    (wr_byte),
    .busy       (busy),
    .go_write   (go_write),
    .go_read    (go_read),
    .go_addr    (go_addr),
    .go_wdata   (go_wdata),
    .second_byte(second_byte)
  );

  ixwin_access u_access (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_write (go_write),
    .go_read  (go_read),
    .go_addr  (go_addr),
    .go_wdata (go_wdata),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .rd_buf   (rd_buf)
  );

  ixwin_readout u_readout (
    .clk    (clk),
    .rst_n  (rst_n),
    .sub_stb(sub_stb),
    .rd_stb (rd_stb),
    .rd_buf (rd_buf),
    .rd_byte(rd_byte)
  );

  assign busy = mem_req;

  // R3/R4: an access only ever starts on the second byte of a pair
  assert_second_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_write || go_read) |-> second_byte);

  assert_one_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_write, go_read}));

endmodule

// File: tb/sim_ixwin_bridge.sv
module sim_ixwin_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_stb = 1'b0;
  logic [7:0]  sub_code = 8'h00;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_byte = 8'h00;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_byte;
  logic        busy;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0000;
  logic        mem_ack = 1'b0;

  localparam logic [7:0] S_RADDR = 8'h35;
  localparam logic [7:0] S_WADDR = 8'h36;
  localparam logic [7:0] S_DATA  = 8'h37;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // memory model state
  int          lat_cfg = 0;
  int          lat_cnt = 0;
  int          n_wr = 0;
  int          n_rd = 0;
  logic [15:0] seen_wa = 16'h0;
  logic [15:0] seen_wd = 16'h0;
  logic [15:0] seen_ra = 16'h0;

  always #4 clk = ~clk;

  ixwin_bridge u0 (
    .clk(clk), .rst_n(rst_n), .sub_stb(sub_stb), .sub_code(sub_code),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_byte(rd_byte),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // content the model returns for an address
  function automatic logic [15:0] mem_value(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + 8'h33};
  endfunction

  function automatic logic [7:0] hi_of(input logic [15:0] w);
    return w >> 8;
  endfunction

  function automatic logic [7:0] lo_of(input logic [15:0] w);
    return w[7:0];
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat_cnt >= lat_cfg) begin
        mem_ack   <= 1'b1;
        lat_cnt   <= 0;
        mem_rdata <= mem_value(mem_addr);
        if (mem_we) begin
          n_wr    = n_wr + 1;
          seen_wa = mem_addr;
          seen_wd = mem_wdata;
        end else begin
          n_rd    = n_rd + 1;
          seen_ra = mem_addr;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_sub(input logic [7:0] c);
    @(negedge clk); sub_stb = 1'b1; sub_code = c;
    @(negedge clk); sub_stb = 1'b0;
  endtask

  task automatic put_byte_raw(input logic [7:0] b);
    @(negedge clk); wr_stb = 1'b1; wr_byte = b;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    put_byte_raw(b);
    settle();
  endtask

  task automatic get_byte(output logic [7:0] b);
    @(negedge clk); b = rd_byte; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d);
    int w0;
    put_sub(S_WADDR); put_byte(hi_of(a)); put_byte(lo_of(a));
    put_sub(S_DATA);  put_byte(hi_of(d));
    w0 = n_wr;
    put_byte(lo_of(d));
    check("R3 write count", 16'(n_wr - w0), 16'd1);
    check("R2 write target", seen_wa, a);
    check("R3 write data", seen_wd, d);
  endtask

  task automatic do_read(input logic [15:0] a);
    logic [7:0] h, l;
    put_sub(S_RADDR); put_byte(hi_of(a)); put_byte(lo_of(a));
    check("R4 read address", seen_ra, a);
    put_sub(S_DATA);
    get_byte(h); get_byte(l);
    check("R5 read high byte", {8'h0, h}, {8'h0, hi_of(mem_value(a))});
    check("R5 read low byte", {8'h0, l}, {8'h0, lo_of(mem_value(a))});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] b0, b1;
    int w0, r0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and empty buffer
    check("R1 busy", {15'h0, busy}, 16'h0);
    check("R1 mem_req", {15'h0, mem_req}, 16'h0);
    put_sub(S_DATA);
    get_byte(b0); get_byte(b1);
    check("R1 empty buffer", {b0, b1}, 16'h0000);

    // R2/R3/R6: directed write with a slow acknowledge
    lat_cfg = 3;
    put_sub(S_WADDR); put_byte(8'h12); put_byte(8'h34);
    put_sub(S_DATA);
    w0 = n_wr;
    put_byte(8'hAB);
    check("R3 no access after first byte", {15'h0, mem_req}, 16'h0);
    put_byte_raw(8'hCD);
    check("R3 req after second byte", {15'h0, mem_req}, 16'h1);
    check("R6 busy during wait", {15'h0, busy}, 16'h1);
    check("R3 we", {15'h0, mem_we}, 16'h1);
    check("R2 target", mem_addr, 16'h1234);
    check("R3 data", mem_wdata, 16'hABCD);
    @(negedge clk);
    check("R6 req held", {15'h0, mem_req}, 16'h1);
    check("R6 addr held", mem_addr, 16'h1234);
    settle();
    check("R6 busy released", {15'h0, busy}, 16'h0);
    check("R3 one write", 16'(n_wr - w0), 16'd1);

    // R9: a second pair under the same subaddress
    put_byte(8'h11); put_byte(8'h22);
    check("R9 second write count", 16'(n_wr - w0), 16'd2);
    check("R9 second write target", seen_wa, 16'h1234);
    check("R9 second write data", seen_wd, 16'h1122);

    // R4/R5: directed read, then pointer reset
    lat_cfg = 2;
    put_sub(S_RADDR); put_byte(8'hBE);
    put_byte_raw(8'hEF);
    check("R4 read req", {15'h0, mem_req}, 16'h1);
    check("R4 read we", {15'h0, mem_we}, 16'h0);
    check("R4 read addr", mem_addr, 16'hBEEF);
    settle();
    put_sub(S_DATA);
    get_byte(b0);
    check("R5 high first", {8'h0, b0}, {8'h0, hi_of(mem_value(16'hBEEF))});
    put_sub(S_DATA);
    get_byte(b0); get_byte(b1);
    check("R5 pointer reset", {b0, b1}, mem_value(16'hBEEF));

    // R7: abandoned pairs start nothing
    lat_cfg = 0;
    w0 = n_wr; r0 = n_rd;
    put_sub(S_DATA);  put_byte(8'hAA);
    put_sub(S_WADDR);
    put_sub(S_DATA);  put_byte(8'hBB);
    check("R7 no write from split pair", 16'(n_wr - w0), 16'd0);
    put_byte(8'hCC);
    check("R7 fresh pair data", seen_wd, 16'hBBCC);
    put_sub(S_RADDR); put_byte(8'h77);
    put_sub(S_DATA);
    check("R7 no read from split pair", 16'(n_rd - r0), 16'd0);

    // R8: foreign subaddress is ignored
    w0 = n_wr; r0 = n_rd;
    put_sub(8'h40);
    for (int i = 0; i < 4; i++) put_byte(8'h90 + 8'(i));
    check("R8 no write", 16'(n_wr - w0), 16'd0);
    check("R8 no read", 16'(n_rd - r0), 16'd0);
    put_sub(S_DATA); put_byte(8'h5E); put_byte(8'h5F);
    check("R8 target unchanged", seen_wa, 16'h1234);

    // random mix
    for (int k = 0; k < 40; k++) begin
      lat_cfg = int'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) do_write(16'($urandom), 16'($urandom));
      else do_read(16'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule